// File: doc/BRIEF.md
# Reduced-Subset Bus Transfer Rule Monitor

This block watches, without driving anything, the address phase of a 32-bit AHB-Lite master interface. It checks each transfer against a reduced subset of the protocol. A simplified slave built for such a master may depend on that subset: short bursts only, word-wide at most, never spanning an 8-byte line, always data accesses, and aligned whenever the target is device-like or the access is locked. A sideband input says, for each transfer, whether the target is device or strongly-ordered memory or normal memory.

Each broken rule sets its own bit in a violation bitmask. The bitmask holds its value until a clear pulse, and a summary error flag goes high whenever any bit is set. To decide whether a sequential beat is legal, the monitor keeps a short history of the current burst: whether a burst is open, how many beats it has had, how many bytes it has moved, and the next address it expects. It does not check the data phase, slave responses or the rest of the protocol.

Top module: `busRuleMon`

## Requirements
- R1: After reset, `violMask` and `errFlag` are zero. A transfer is evaluated only in a cycle where `readyIn` is 1 and `transType` is NONSEQ (2'b10) or SEQ (2'b11). BUSY (2'b01) is evaluated only when `readyIn` is 1. A transfer evaluated at one rising edge shows in `violMask` just after that edge, and while `readyIn` is 0 the mask does not change.
- R2: Bit 0 is set by an evaluated transfer whose `burstType` is neither SINGLE (3'b000) nor INCR (3'b001).
- R3: Bit 1 is set when `transType` is BUSY and `readyIn` is 1.
- R4: Bit 2 is set in two cases: a SEQ beat arrives after a burst already has two beats, or the bytes of the burst so far plus this beat's 2^`sizeCode` bytes exceed 8. A NONSEQ beat starts a new byte count.
- R5: Bit 3 is set when a beat covers bytes on both sides of an 8-byte-aligned address. That is the case when `addr[2:0]` + 2^`sizeCode` > 8.
- R6: Bit 4 is set when `sizeCode` is above 2. Size codes 0, 1 and 2 mean 8, 16 and 32 bits.
- R7: Bit 5 is set when a SEQ beat has `sizeCode` 0 or 1, so byte and halfword transfers are single only.
- R8: Bit 6 is set when `protBits[0]` is 0 on an evaluated transfer.
- R9: Bit 7 is set when `devMem` or `lockReq` is 1 and `addr` is not a multiple of 2^`sizeCode`. A misaligned transfer to normal memory with `lockReq` at 0 does not set this bit.
- R10: Bit 8 is set by a SEQ beat that has no open INCR burst before it, or whose address is not the previous beat's address plus that beat's byte count.
- R11: Mask bits are sticky. A `clearViol` pulse loads the mask with only the violations evaluated in that same cycle. `errFlag` is 1 exactly when the mask is nonzero.
- R12: A NONSEQ with INCR opens a burst. A NONSEQ with SINGLE closes it. An accepted IDLE closes it. A BUSY leaves the burst state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| clearViol | input | 1 | One-cycle pulse that reloads the mask |
| transType | input | 2 | Transfer type of the address phase |
| burstType | input | 3 | Burst encoding |
| sizeCode | input | 3 | Transfer size, log2 of the byte count |
| addr | input | ADDR_W | Transfer address |
| protBits | input | 4 | Protection attributes; bit 0 marks a data access |
| lockReq | input | 1 | Locked transfer |
| devMem | input | 1 | 1 = device or strongly-ordered target |
| readyIn | input | 1 | Bus ready; address phase is accepted when 1 |
| violMask | output | 9 | Sticky per-rule violation bits |
| errFlag | output | 1 | 1 when any violation bit is held |

## Verification
The hardest cases to reach are the ones that depend on burst history: a third beat, a SEQ with the wrong address, a SEQ after an IDLE, a SINGLE or a closed burst, and a SEQ separated from its NONSEQ by BUSY or stall cycles. The stimulus builds these as back-to-back address phases. BUSY cycles and cycles with `readyIn` low are placed inside open bursts. A behavioural model of the burst history predicts the mask on every clock. A clear pulse is also issued in the same cycle as a fresh violation, to show that the new violation survives the clear.

// File: rtl/ruleMonPkg.sv
`timescale 1ns/1ps
package ruleMonPkg;
  localparam int TRANS_W = 2;
  localparam int BURST_W = 3;
  localparam int SIZE_W  = 3;
  localparam int PROT_W  = 4;
  // enough bits to hold 2^(2^SIZE_W - 1)
  localparam int BYTES_W = 2 ** SIZE_W;

  localparam logic [TRANS_W-1:0] TR_IDLE   = 2'b00;
  localparam logic [TRANS_W-1:0] TR_BUSY   = 2'b01;
  localparam logic [TRANS_W-1:0] TR_NONSEQ = 2'b10;
  localparam logic [TRANS_W-1:0] TR_SEQ    = 2'b11;

  localparam logic [BURST_W-1:0] BU_SINGLE = 3'b000;
  localparam logic [BURST_W-1:0] BU_INCR   = 3'b001;

  // rule bit positions in the violation mask
  localparam int RL_BURST  = 0;
  localparam int RL_BUSY   = 1;
  localparam int RL_LENGTH = 2;
  localparam int RL_CROSS  = 3;
  localparam int RL_SIZE   = 4;
  localparam int RL_NARROW = 5;
  localparam int RL_PROT   = 6;
  localparam int RL_ALIGN  = 7;
  localparam int RL_ORDER  = 8;
  localparam int RULE_N    = 9;

  // strobes from burst tracking to the rule datapath
  typedef struct packed {
    logic accept;
    logic isSeq;
    logic seqOrphan;
    logic seqAddrBad;
    logic overBeats;
    logic overBytes;
  } ctrlStrobe_t;

  function automatic logic [BYTES_W-1:0] sizeBytes(input logic [SIZE_W-1:0] sz);
    return BYTES_W'(1) << sz;
  endfunction
endpackage

// File: rtl/ruleCtrl.sv
`timescale 1ns/1ps
module ruleCtrl
  import ruleMonPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 2,
  parameter int MAX_BYTES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TRANS_W-1:0] transType,
  input  logic [BURST_W-1:0] burstType,
  input  logic [SIZE_W-1:0]  sizeCode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               readyIn,
  output ctrlStrobe_t        strb
);
  localparam int CNT_W = $clog2(MAX_BEATS + 1);
  localparam int TOT_W = BYTES_W + $clog2(MAX_BYTES + 2) + 1;
  localparam logic [TOT_W-1:0] TOT_CAP = TOT_W'(MAX_BYTES + 1);

  typedef enum logic {PH_OPEN, PH_BURST} phase_t;

  phase_t             phase, phaseNext;
  logic [CNT_W-1:0]   beatCnt, beatNext;
  logic [TOT_W-1:0]   byteTot, totNext, totSum;
  logic [ADDR_W-1:0]  expAddr, expNext;
  logic [BYTES_W-1:0] beatBytes;
  logic               accept, seqBeat, idleBeat;

  always_comb begin
    beatBytes = sizeBytes(sizeCode);
    accept    = readyIn && (transType == TR_NONSEQ || transType == TR_SEQ);
    seqBeat   = accept && (transType == TR_SEQ);
    idleBeat  = readyIn && (transType == TR_IDLE);
    totSum    = (seqBeat ? byteTot : '0) + TOT_W'(beatBytes);
  end

  always_comb begin
    strb            = '0;
    strb.accept     = accept;
    strb.isSeq      = seqBeat;
    strb.seqOrphan  = seqBeat && (phase != PH_BURST);
    strb.seqAddrBad = seqBeat && (phase == PH_BURST) && (addr != expAddr);
    strb.overBeats  = seqBeat && (beatCnt >= CNT_W'(MAX_BEATS));
    strb.overBytes  = accept && (totSum > TOT_W'(MAX_BYTES));
  end

  always_comb begin
    phaseNext = phase;
    beatNext  = beatCnt;
    totNext   = byteTot;
    expNext   = expAddr;
    if (accept) begin
      expNext = addr + ADDR_W'(beatBytes);
      totNext = (totSum > TOT_CAP) ? TOT_CAP : totSum;
      if (seqBeat) begin
        if (beatCnt < CNT_W'(MAX_BEATS)) beatNext = beatCnt + CNT_W'(1);
      end else begin
        beatNext  = CNT_W'(1);
        phaseNext = (burstType == BU_INCR) ? PH_BURST : PH_OPEN;
      end
    end else if (idleBeat) begin
      phaseNext = PH_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_OPEN;
      beatCnt <= '0;
      byteTot <= '0;
      expAddr <= '0;
    end else begin
      phase   <= phaseNext;
      beatCnt <= beatNext;
      byteTot <= totNext;
      expAddr <= expNext;
    end
  end
endmodule

// File: rtl/ruleData.sv
`timescale 1ns/1ps
module ruleData
  import ruleMonPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_SIZE   = 2,
  parameter int BOUND_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clearViol,
  input  logic [TRANS_W-1:0] transType,
  input  logic [BURST_W-1:0] burstType,
  input  logic [SIZE_W-1:0]  sizeCode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               dataAccess,
  input  logic               lockReq,
  input  logic               devMem,
  input  logic               readyIn,
  input  ctrlStrobe_t        strb,
  output logic [RULE_N-1:0]  violMask,
  output logic               errFlag
);
  localparam int OFF_W = BYTES_W + BOUND_LOG2 + 1;
  localparam logic [OFF_W-1:0] SPAN = OFF_W'(1) << BOUND_LOG2;

  logic [RULE_N-1:0]  hit;
  logic [BYTES_W-1:0] beatBytes;
  logic [OFF_W-1:0]   offSum;
  logic               misAligned;

  always_comb begin
    beatBytes  = sizeBytes(sizeCode);
    offSum     = OFF_W'(addr[BOUND_LOG2-1:0]) + OFF_W'(beatBytes);
    misAligned = 1'b0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i < int'(sizeCode)) misAligned = misAligned | addr[i];
    end
  end

  always_comb begin
    hit            = '0;
    hit[RL_BURST]  = strb.accept && !(burstType == BU_SINGLE || burstType == BU_INCR);
    hit[RL_BUSY]   = readyIn && (transType == TR_BUSY);
    hit[RL_LENGTH] = strb.overBeats || strb.overBytes;
    hit[RL_CROSS]  = strb.accept && (offSum > SPAN);
    hit[RL_SIZE]   = strb.accept && (sizeCode > SIZE_W'(MAX_SIZE));
    hit[RL_NARROW] = strb.isSeq && (sizeCode < SIZE_W'(MAX_SIZE));
    hit[RL_PROT]   = strb.accept && !dataAccess;
    hit[RL_ALIGN]  = strb.accept && (devMem || lockReq) && misAligned;
    hit[RL_ORDER]  = strb.seqOrphan || strb.seqAddrBad;
  end

  for (genvar g = 0; g < RULE_N; g++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          violMask[g] <= 1'b0;
      else if (clearViol) violMask[g] <= hit[g];
      else if (hit[g])    violMask[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          errFlag <= 1'b0;
    else if (clearViol) errFlag <= |hit;
    else if (|hit)      errFlag <= 1'b1;
  end
endmodule

// File: rtl/busRuleMon.sv
`timescale 1ns/1ps
module busRuleMon
  import ruleMonPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_BEATS  = 2,
  parameter int MAX_BYTES  = 8,
  parameter int MAX_SIZE   = 2,
  parameter int BOUND_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clearViol,
  input  logic [TRANS_W-1:0] transType,
  input  logic [BURST_W-1:0] burstType,
  input  logic [SIZE_W-1:0]  sizeCode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [PROT_W-1:0]  protBits,
  input  logic               lockReq,
  input  logic               devMem,
  input  logic               readyIn,
  output logic [RULE_N-1:0]  violMask,
  output logic               errFlag
);
  ctrlStrobe_t strb;
  logic        unusedProtHi;

  assign unusedProtHi = ^protBits[PROT_W-1:1];

  ruleCtrl #(
    .ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS), .MAX_BYTES(MAX_BYTES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .transType(transType), .burstType(burstType),
    .sizeCode(sizeCode), .addr(addr), .readyIn(readyIn), .strb(strb)
  );

  ruleData #(
    .ADDR_W(ADDR_W), .MAX_SIZE(MAX_SIZE), .BOUND_LOG2(BOUND_LOG2)
  ) uData (
    .clk(clk), .rstN(rstN), .clearViol(clearViol), .transType(transType),
    .burstType(burstType), .sizeCode(sizeCode), .addr(addr),
    .dataAccess(protBits[0]), .lockReq(lockReq), .devMem(devMem),
    .readyIn(readyIn), .strb(strb), .violMask(violMask), .errFlag(errFlag)
  );
endmodule

// File: rtl/ruleMonChecker.sv
`timescale 1ns/1ps
module ruleMonChecker
  import ruleMonPkg::*;
#(
  parameter int MAX_SIZE = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               clearViol,
  input logic [TRANS_W-1:0] transType,
  input logic [BURST_W-1:0] burstType,
  input logic [SIZE_W-1:0]  sizeCode,
  input logic [PROT_W-1:0]  protBits,
  input logic               readyIn,
  input logic [RULE_N-1:0]  violMask,
  input logic               errFlag
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!readyIn && !clearViol) |=> (violMask == $past(violMask))); // R1
  AST_BURST_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (readyIn && transType[1] && burstType > BU_INCR) |=> violMask[RL_BURST]); // R2
  AST_BUSY_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    (readyIn && transType == TR_BUSY) |=> violMask[RL_BUSY]); // R3
  AST_WIDE_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (readyIn && transType[1] && sizeCode > SIZE_W'(MAX_SIZE)) |=> violMask[RL_SIZE]); // R6
  AST_INSTR_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (readyIn && transType[1] && !protBits[0]) |=> violMask[RL_PROT]); // R8
  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (!clearViol) |=> ((violMask & $past(violMask)) == $past(violMask))); // R11
  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag == (violMask != '0)); // R11
endmodule

bind busRuleMon ruleMonChecker #(.MAX_SIZE(MAX_SIZE)) uRuleChk (.*);

// File: tb/sim_busRuleMon.sv
`timescale 1ns/1ps
module sim_busRuleMon;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearViol = 1'b0;
  logic [1:0]  transType = 2'b00;
  logic [2:0]  burstType = 3'b000;
  logic [2:0]  sizeCode = 3'd2;
  logic [31:0] addr = '0;
  logic [3:0]  protBits = 4'h1;
  logic        lockReq = 1'b0;
  logic        devMem = 1'b0;
  logic        readyIn = 1'b1;
  logic [8:0]  violMask;
  logic        errFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  bit        mInBurst = 0;
  int        mBeats = 0;
  int        mTot = 0;
  bit [31:0] mExp = '0;
  bit [8:0]  mMask = '0;

  always #4 clk = ~clk;

  busRuleMon u0 (
    .clk(clk), .rstN(rstN), .clearViol(clearViol), .transType(transType),
    .burstType(burstType), .sizeCode(sizeCode), .addr(addr), .protBits(protBits),
    .lockReq(lockReq), .devMem(devMem), .readyIn(readyIn),
    .violMask(violMask), .errFlag(errFlag)
  );

  task automatic modelEdge();
    int        bytes = 1 << sizeCode;
    bit        act = readyIn && transType[1];
    bit        seq = act && (transType == 2'b11);
    bit [8:0]  nv = '0;
    bit [31:0] mis = addr & (bytes - 1);
    nv[0] = act && (burstType > 3'd1);
    nv[1] = readyIn && (transType == 2'b01);
    nv[2] = act && (((seq ? mTot : 0) + bytes > 8) || (seq && mBeats >= 2));
    nv[3] = act && ((addr % 8) + bytes > 8);
    nv[4] = act && (sizeCode > 3'd2);
    nv[5] = seq && (sizeCode < 3'd2);
    nv[6] = act && !protBits[0];
    nv[7] = act && (devMem || lockReq) && (mis != 0);
    nv[8] = seq && (!mInBurst || addr != mExp);
    if (act) begin
      if (seq) begin
        mBeats++;
        mTot += bytes;
      end else begin
        mInBurst = (burstType == 3'd1);
        mBeats = 1;
        mTot = bytes;
      end
      mExp = addr + bytes;
    end else if (readyIn && transType == 2'b00) begin
      mInBurst = 0;
    end
    mMask = clearViol ? nv : (mMask | nv);
  endtask

  task automatic compare(input string tag);
    total++;
    if (violMask !== mMask || errFlag !== (mMask != 0)) begin
      bad++;
      $display("FAIL %s: mask=%b err=%b expected mask=%b err=%b",
               tag, violMask, errFlag, mMask, (mMask != 0));
    end
  endtask

  task automatic step(input logic [1:0] tr, input logic [2:0] bu, input logic [2:0] sz,
                      input logic [31:0] ad, input logic [3:0] pr, input logic lk,
                      input logic rdy, input logic dv, input logic clr, input string tag);
    transType = tr; burstType = bu; sizeCode = sz; addr = ad;
    protBits = pr; lockReq = lk; readyIn = rdy; devMem = dv; clearViol = clr;
    @(posedge clk);
    modelEdge();
    #1;
    compare(tag);
  endtask

  task automatic ok(input logic [1:0] tr, input logic [2:0] bu, input logic [2:0] sz,
                    input logic [31:0] ad, input string tag);
    step(tr, bu, sz, ad, 4'h1, 1'b0, 1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic clr(input string tag);
    step(2'b00, 3'd0, 3'd2, 32'h0, 4'h1, 1'b0, 1'b1, 1'b0, 1'b1, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (violMask !== '0 || errFlag !== 1'b0) begin
      bad++;
      $display("FAIL R1: reset mask=%b err=%b expected 0 0", violMask, errFlag);
    end
    rstN = 1'b1;
    // R1: legal word, idle, stalled illegal transfer ignored
    ok(2'b10, 3'd0, 3'd2, 32'h100, "R1");
    ok(2'b00, 3'd0, 3'd2, 32'h0, "R1");
    step(2'b10, 3'd3, 3'd3, 32'h101, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, "R1");
    // R4: two-beat word burst legal, third beat flagged
    ok(2'b10, 3'd1, 3'd2, 32'h200, "R4");
    ok(2'b11, 3'd1, 3'd2, 32'h204, "R4");
    ok(2'b10, 3'd1, 3'd2, 32'h208, "R4");
    ok(2'b11, 3'd1, 3'd2, 32'h20C, "R4");
    ok(2'b11, 3'd1, 3'd2, 32'h210, "R4");
    clr("R11");
    // R2: fixed-length burst encoding
    ok(2'b10, 3'd3, 3'd2, 32'h40, "R2");
    clr("R11");
    // R3: BUSY with ready, then BUSY stalled ignored (R1)
    ok(2'b01, 3'd1, 3'd2, 32'h44, "R3");
    clr("R11");
    step(2'b01, 3'd1, 3'd2, 32'h44, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R6: doubleword aligned, doubleword crossing line
    ok(2'b10, 3'd0, 3'd3, 32'h0, "R6");
    ok(2'b10, 3'd0, 3'd3, 32'h4, "R6");
    clr("R11");
    // R5: boundary crossing in normal memory
    ok(2'b10, 3'd0, 3'd1, 32'h6, "R5");
    ok(2'b10, 3'd0, 3'd0, 32'h7, "R5");
    ok(2'b10, 3'd0, 3'd1, 32'h7, "R5");
    clr("R11");
    ok(2'b10, 3'd0, 3'd2, 32'h5, "R5");
    clr("R11");
    // R7: byte in a two-beat burst
    ok(2'b10, 3'd1, 3'd0, 32'h300, "R7");
    ok(2'b11, 3'd1, 3'd0, 32'h301, "R7");
    clr("R11");
    // R8: instruction-type access
    step(2'b10, 3'd0, 3'd2, 32'h310, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    clr("R11");
    // R9: alignment depends on target type and lock
    step(2'b10, 3'd0, 3'd2, 32'h402, 4'h1, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
    step(2'b10, 3'd0, 3'd1, 32'h402, 4'h1, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
    step(2'b10, 3'd0, 3'd2, 32'h402, 4'h1, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
    clr("R11");
    step(2'b10, 3'd0, 3'd1, 32'h401, 4'h1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    clr("R11");
    // R10: orphan SEQ and wrong-address SEQ
    ok(2'b11, 3'd1, 3'd2, 32'h500, "R10");
    clr("R11");
    ok(2'b10, 3'd1, 3'd2, 32'h600, "R10");
    ok(2'b11, 3'd1, 3'd2, 32'h608, "R10");
    clr("R11");
    // R12: BUSY keeps burst open, IDLE and SINGLE close it
    ok(2'b10, 3'd1, 3'd2, 32'h700, "R12");
    ok(2'b01, 3'd1, 3'd2, 32'h704, "R12");
    ok(2'b11, 3'd1, 3'd2, 32'h704, "R12");
    clr("R11");
    ok(2'b10, 3'd1, 3'd2, 32'h710, "R12");
    ok(2'b00, 3'd0, 3'd2, 32'h0, "R12");
    ok(2'b11, 3'd1, 3'd2, 32'h714, "R12");
    clr("R11");
    ok(2'b10, 3'd0, 3'd2, 32'h720, "R12");
    ok(2'b11, 3'd1, 3'd2, 32'h724, "R12");
    clr("R11");
    ok(2'b10, 3'd1, 3'd2, 32'h730, "R12");
    ok(2'b11, 3'd1, 3'd2, 32'h734, "R12");
    ok(2'b10, 3'd1, 3'd2, 32'h738, "R12");
    ok(2'b11, 3'd1, 3'd2, 32'h73C, "R12");
    // R1: stall inside a burst leaves it intact
    ok(2'b10, 3'd1, 3'd2, 32'h800, "R1");
    step(2'b11, 3'd1, 3'd2, 32'h900, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    ok(2'b11, 3'd1, 3'd2, 32'h804, "R1");
    // R11: fresh violation survives a same-cycle clear
    ok(2'b01, 3'd0, 3'd2, 32'h0, "R11");
    step(2'b10, 3'd0, 3'd2, 32'h810, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
    ok(2'b00, 3'd0, 3'd2, 32'h0, "R11");
    clr("R11");
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule